// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block sits in front of a small on-chip byte-laned memory and turns the classic burst-SRAM control pins into memory cycles. Each rising clock edge samples three chip enables, two address strobes (a host strobe and a controller strobe), an advance input and the write controls. The decode gives one cycle type: deselect, burst start, burst continue or burst suspend, each a read or a write. Writes go to the memory through per-byte write enables. Reads return through an output stage that either bypasses or uses an extra output register, chosen by a mode input.

Burst address sequencing lives outside the block. The block tells an external counter when to load (a burst start) and when to step (a burst continue), one cycle after the edge that sampled the request. On every cycle the address input carries the address to use: the external address on a start, and the counter value on continue and suspend cycles. The read bus has a drive-enable output that models the tri-state control. An asynchronous active-low output enable can turn it off at any time. The part uses single-cycle deselect, so a read followed by a write needs either a deselect or a read with the output enable high (a dummy read) in between.

Top module: `sburst_ctrl`

## Requirements
- R1: The part is enabled only when `en_b` is 1 and both `en_a_n` and `en_c_n` are 0. A strobe sampled while the part is not enabled gives a deselect: no memory write, no counter load, and the block becomes unselected.
- R2: With `strb_host_n`=0 and `en_a_n`=0 on an enabled edge, a read burst starts at `addr_i` whatever the write inputs are. `cnt_load_o` is 1 for the cycle after that edge.
- R3: `en_a_n`=1 masks `strb_host_n`. With `strb_ctl_n`=1 the edge is then treated as a burst continue or suspend, not as a start or a deselect.
- R4: With `strb_ctl_n`=0, `strb_host_n` seen as high and the part enabled, a burst starts at `addr_i`. It is a read or a write by the write decode (R6), and write data and byte enables are taken on that same edge. `cnt_load_o` is 1 for the next cycle.
- R5: With both strobes seen as high while selected (after a start, before a deselect), `step_n`=0 gives a continue and `cnt_step_o`=1 for the next cycle. `step_n`=1 gives a suspend with no step. Both follow the write decode. While unselected these edges neither write nor read. `cnt_load_o` and `cnt_step_o` are never 1 together.
- R6: Write decode: `wr_all_n`=0 writes all bytes. Otherwise `wr_byte_n`=0 writes byte i (data bits 8i+7..8i) exactly when `lane_n[i]`=0, and with all `lane_n` bits 1 it writes nothing. Both `wr_all_n` and `wr_byte_n` at 1 means a read.
- R7: With `pipe_sel_i`=0 the read data and drive appear after the edge that samples the read. With `pipe_sel_i`=1 they appear one edge later. All bytes are driven on a read.
- R8: In the cycle after any edge that samples a write, `q_drv_o` is 0 in both modes.
- R9: `out_en_n`=1 forces `q_drv_o` to 0 at once. A read sampled with `out_en_n`=1 (a dummy read) still loads or steps the counter as a normal read does.
- R10: Single-cycle deselect in pipeline mode: after a deselect sampled at edge k, data from a read at edge k-1 still drives after edge k, and the drive is released after edge k+1.
- R11: After reset `q_drv_o`, `cnt_load_o` and `cnt_step_o` are 0 and the block is unselected. `q_o` reads 0 whenever `q_drv_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | AW | Cycle address (external or counter value) |
| en_a_n | input | 1 | Chip enable A, active low; also masks the host strobe |
| en_b | input | 1 | Chip enable B, active high |
| en_c_n | input | 1 | Chip enable C, active low |
| strb_host_n | input | 1 | Host address strobe, active low, read start |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_n | input | 1 | Byte-write qualifier, active low |
| lane_n | input | NB | Per-byte write enables, active low |
| pipe_sel_i | input | 1 | 1 = pipelined output register, 0 = flow-through |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| wdata_i | input | NB*8 | Write data |
| q_o | output | NB*8 | Read data, 0 when not driven |
| q_drv_o | output | 1 | Read bus drive enable |
| cnt_load_o | output | 1 | Load pulse for the external burst counter |
| cnt_step_o | output | 1 | Advance pulse for the external burst counter |

## Verification
The test first writes known words through controller-strobe starts, then applies byte writes with mixed lane masks and a byte write with no lane selected. Reading these words back shows whether global, partial and empty writes are told apart. Host-strobe reads are given with the write inputs held active, which shows that the host strobe always reads. Continue and suspend edges run while selected and while unselected, and one runs with the host strobe masked by `en_a_n`. This separates stepping, holding and ignored cycles through the counter pulses and the read-back data. The same read streams then run in both output modes, with a deselect, a write right after a read, and a dummy read. These show the one-edge against two-edge latency, the single-cycle deselect release, write quieting, and output enable gating.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_DESEL = 3'd1,
    OP_START = 3'd2,
    OP_NEXT  = 3'd3,
    OP_HOLD  = 3'd4
  } op_e;
endpackage

// File: rtl/sbc_decode.sv
module sbc_decode
  import sbc_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_a_n,
  input  logic          en_b,
  input  logic          en_c_n,
  input  logic          strb_host_n,
  input  logic          strb_ctl_n,
  input  logic          step_n,
  input  logic          wr_all_n,
  input  logic          wr_byte_n,
  input  logic [NB-1:0] lane_n,
  output op_e           op_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic [NB-1:0] mask_o,
  output logic          sel_o
);
  logic          enabled;
  logic          wdec;
  logic          host_seen;
  logic [NB-1:0] lanes;
  logic          sel_q;

  always_comb begin
    enabled   = en_b & ~en_a_n & ~en_c_n;
    host_seen = ~strb_host_n & ~en_a_n;
    wdec      = ~wr_all_n | ~wr_byte_n;
    if (!wr_all_n)       lanes = '1;
    else if (!wr_byte_n) lanes = ~lane_n;
    else                 lanes = '0;
    op_o = OP_IDLE;
    rd_o = 1'b0;
    wr_o = 1'b0;
    if (host_seen) begin
      op_o = enabled ? OP_START : OP_DESEL;
      rd_o = enabled;
    end else if (!strb_ctl_n) begin
      op_o = enabled ? OP_START : OP_DESEL;
      rd_o = enabled & ~wdec;
      wr_o = enabled & wdec;
    end else if (sel_q) begin
      op_o = step_n ? OP_HOLD : OP_NEXT;
      rd_o = ~wdec;
      wr_o = wdec;
    end
    mask_o = wr_o ? lanes : '0;
  end

  always_ff @(posedge clk) begin
    if (rst)                    sel_q <= 1'b0;
    else if (op_o == OP_START)  sel_q <= 1'b1;
    else if (op_o == OP_DESEL)  sel_q <= 1'b0;
  end

  assign sel_o = sel_q;

  AST_UNSEL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!sel_q && strb_host_n && strb_ctl_n) |-> (!rd_o && !wr_o)); // R5
  AST_DESEL_DROPS: assert property (@(posedge clk) disable iff (rst)
    (op_o == OP_DESEL) |=> !sel_o); // R1
endmodule

// File: rtl/sbc_bytemem.sv
module sbc_bytemem #(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic [NB-1:0]    we_i,
  input  logic             re_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [NB*BW-1:0] wdata_i,
  output logic [NB*BW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [BW-1:0] store [DEPTH];
    logic [BW-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (we_i[g]) store[addr_i] <= wdata_i[g*BW +: BW];
      if (re_i)    lane_q <= store[addr_i];
    end
    assign rdata_o[g*BW +: BW] = lane_q;
  end

  AST_RW_EXCL: assert property (@(posedge clk) (|we_i) |-> !re_i); // R6
endmodule

// File: rtl/sbc_outstage.sv
module sbc_outstage #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pipe_sel_i,
  input  logic          out_en_n,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic          desel_i,
  input  logic [DW-1:0] ft_data_i,
  output logic [DW-1:0] q_o,
  output logic          q_drv_o
);
  logic          ft_v;
  logic          pl_v;
  logic          wr_q;
  logic [DW-1:0] pl_d;
  logic          stage_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      ft_v <= 1'b0;
      pl_v <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      ft_v <= rd_i;
      pl_v <= ft_v;
      wr_q <= wr_i;
    end
  end

  always_ff @(posedge clk) pl_d <= ft_data_i;

  always_comb begin
    stage_v = pipe_sel_i ? pl_v : ft_v;
    q_drv_o = stage_v & ~wr_q & ~out_en_n;
    if (!q_drv_o)        q_o = '0;
    else if (pipe_sel_i) q_o = pl_d;
    else                 q_o = ft_data_i;
  end

  AST_WR_QUIET: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> !q_drv_o); // R8
  AST_OE_OFF: assert property (@(posedge clk) disable iff (rst)
    out_en_n |-> !q_drv_o); // R9
  AST_FT_LAT: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !pipe_sel_i) |=> (pipe_sel_i || out_en_n || q_drv_o)); // R7
  AST_SCD_REL: assert property (@(posedge clk) disable iff (rst)
    (desel_i && pipe_sel_i) ##1 pipe_sel_i |=> !q_drv_o); // R10
endmodule

// File: rtl/sburst_ctrl.sv
module sburst_ctrl
  import sbc_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4,
  localparam int BW = 8,
  localparam int DW = NB * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic          en_a_n,
  input  logic          en_b,
  input  logic          en_c_n,
  input  logic          strb_host_n,
  input  logic          strb_ctl_n,
  input  logic          step_n,
  input  logic          wr_all_n,
  input  logic          wr_byte_n,
  input  logic [NB-1:0] lane_n,
  input  logic          pipe_sel_i,
  input  logic          out_en_n,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o,
  output logic          q_drv_o,
  output logic          cnt_load_o,
  output logic          cnt_step_o
);
  op_e           op;
  logic          rd;
  logic          wr;
  logic          sel;
  logic [NB-1:0] mask;
  logic [DW-1:0] ram_q;

  sbc_decode #(.NB(NB)) u_dec (
    .clk(clk), .rst(rst), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
    .strb_host_n(strb_host_n), .strb_ctl_n(strb_ctl_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n),
    .op_o(op), .rd_o(rd), .wr_o(wr), .mask_o(mask), .sel_o(sel)
  );

  sbc_bytemem #(.AW(AW), .NB(NB), .BW(BW)) u_mem (
    .clk(clk), .we_i(mask), .re_i(rd), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(ram_q)
  );

  sbc_outstage #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .pipe_sel_i(pipe_sel_i), .out_en_n(out_en_n),
    .rd_i(rd), .wr_i(wr), .desel_i(op == OP_DESEL), .ft_data_i(ram_q),
    .q_o(q_o), .q_drv_o(q_drv_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_load_o <= 1'b0;
      cnt_step_o <= 1'b0;
    end else begin
      cnt_load_o <= (op == OP_START);
      cnt_step_o <= (op == OP_NEXT);
    end
  end

  AST_HOST_READS: assert property (@(posedge clk) disable iff (rst)
    (!strb_host_n && !en_a_n) |-> (mask == '0)); // R2
  AST_DESEL_NOLOAD: assert property (@(posedge clk) disable iff (rst)
    (op == OP_DESEL) |=> !cnt_load_o); // R1
  AST_CNT_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cnt_load_o, cnt_step_o})); // R5
  AST_SEL_BEFORE_STEP: assert property (@(posedge clk) disable iff (rst)
    cnt_step_o |-> $past(sel)); // R5
endmodule

// File: tb/sim_sburst_ctrl.sv
module sim_sburst_ctrl;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int DW = NB * 8;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr_i;
  logic          en_a_n, en_b, en_c_n, strb_host_n, strb_ctl_n, step_n;
  logic          wr_all_n, wr_byte_n, pipe_sel_i, out_en_n;
  logic [NB-1:0] lane_n;
  logic [DW-1:0] wdata_i;
  logic [DW-1:0] q_o;
  logic          q_drv_o, cnt_load_o, cnt_step_o;

  always #5 clk = ~clk;

  sburst_ctrl #(.AW(AW), .NB(NB)) u0 (
    .clk(clk), .rst(rst), .addr_i(addr_i), .en_a_n(en_a_n), .en_b(en_b),
    .en_c_n(en_c_n), .strb_host_n(strb_host_n), .strb_ctl_n(strb_ctl_n),
    .step_n(step_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
    .lane_n(lane_n), .pipe_sel_i(pipe_sel_i), .out_en_n(out_en_n),
    .wdata_i(wdata_i), .q_o(q_o), .q_drv_o(q_drv_o),
    .cnt_load_o(cnt_load_o), .cnt_step_o(cnt_step_o)
  );

  typedef struct {
    logic          drv;
    logic [DW-1:0] q;
    logic          ld;
    logic          inc;
    string         tag;
  } exp_t;
  exp_t sb[$];

  int total = 0;
  int fails = 0;

  logic [DW-1:0] m_mem [1<<AW];
  logic          m_sel = 1'b0, ft_v = 1'b0, pl_v = 1'b0, wr_last = 1'b0;
  logic [DW-1:0] ft_d = '0, pl_d = '0;

  task automatic chk(input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle_in();
    en_a_n = 0; en_b = 1; en_c_n = 0;
    strb_host_n = 1; strb_ctl_n = 1; step_n = 1;
    wr_all_n = 1; wr_byte_n = 1; lane_n = '1;
    out_en_n = 0; addr_i = '0; wdata_i = '0;
  endtask

  // Driver: apply the current inputs for one edge and queue what must follow.
  task automatic go(input string tag);
    logic en, wd, rd, wr, st, nx, ds, drv;
    logic [DW-1:0] old;
    en = en_b & !en_a_n & !en_c_n;
    wd = !wr_all_n | !wr_byte_n;
    rd = 0; wr = 0; st = 0; nx = 0; ds = 0;
    if (!strb_host_n && !en_a_n) begin st = en; ds = !en; rd = en; end
    else if (!strb_ctl_n) begin st = en; ds = !en; rd = en & !wd; wr = en & wd; end
    else if (m_sel) begin nx = !step_n; rd = !wd; wr = wd; end
    old = m_mem[addr_i];
    if (wr)
      for (int i = 0; i < NB; i++)
        if (!wr_all_n || (!wr_byte_n && !lane_n[i]))
          m_mem[addr_i][i*8 +: 8] = wdata_i[i*8 +: 8];
    pl_v = ft_v; pl_d = ft_d;
    if (rd) ft_d = old;
    ft_v = rd; wr_last = wr;
    if (st) m_sel = 1; else if (ds) m_sel = 0;
    drv = (pipe_sel_i ? pl_v : ft_v) & !wr_last & !out_en_n;
    sb.push_back('{drv, drv ? (pipe_sel_i ? pl_d : ft_d) : '0, st, nx, tag});
    @(posedge clk);
    @(negedge clk);
    idle_in();
  endtask

  // Monitor: compare outputs a little after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "drive", DW'(q_drv_o), DW'(e.drv));
        chk(e.tag, "data", q_o, e.q);
        chk(e.tag, "load", DW'(cnt_load_o), DW'(e.ld));
        chk(e.tag, "step", DW'(cnt_step_o), DW'(e.inc));
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  task automatic ctl_write(input string tag, input logic [AW-1:0] a,
                           input logic [DW-1:0] d);
    strb_ctl_n = 0; wr_all_n = 0; addr_i = a; wdata_i = d; go(tag);
  endtask

  task automatic host_read(input string tag, input logic [AW-1:0] a);
    strb_host_n = 0; addr_i = a; go(tag);
  endtask

  initial begin
    rst = 1; pipe_sel_i = 0; idle_in();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    chk("R11", "reset drive", DW'(q_drv_o), '0);
    chk("R11", "reset load", DW'(cnt_load_o), '0);
    chk("R11", "reset step", DW'(cnt_step_o), '0);
    chk("R11", "reset data", q_o, '0);

    // Flow-through: controller-strobe writes, R4 R6
    ctl_write("R4", 6'd1, 32'h11223344);
    ctl_write("R4", 6'd2, 32'hAAAAAAAA);
    ctl_write("R4", 6'd4, 32'h44444444);
    ctl_write("R4", 6'd3, 32'h33333333);
    strb_ctl_n = 0; wr_byte_n = 0; lane_n = 4'b1010; addr_i = 2;
    wdata_i = 32'h55667788; go("R6");
    strb_ctl_n = 0; wr_byte_n = 0; lane_n = 4'b1111; addr_i = 1;
    wdata_i = 32'hFFFFFFFF; go("R6");
    // Host strobe reads regardless of write inputs, R2 R7
    strb_host_n = 0; wr_all_n = 0; addr_i = 1; wdata_i = 32'hDEADBEEF; go("R2");
    strb_ctl_n = 0; addr_i = 2; go("R7");
    host_read("R6", 6'd1);
    // Continue write, suspend read, R5
    step_n = 0; wr_all_n = 0; addr_i = 3; wdata_i = 32'h0BADF00D; go("R5");
    step_n = 1; addr_i = 3; go("R5");
    step_n = 0; addr_i = 2; go("R5");
    // Deselect then unselected edges ignored, R1 R5
    strb_ctl_n = 0; en_b = 0; go("R1");
    step_n = 0; wr_all_n = 0; addr_i = 4; wdata_i = 32'h99999999; go("R5");
    strb_host_n = 0; en_c_n = 1; go("R1");
    host_read("R1", 6'd4);
    // Host strobe masked by en_a_n: continue write, R3
    en_a_n = 1; strb_host_n = 0; step_n = 0; wr_all_n = 0; addr_i = 5;
    wdata_i = 32'h5A5A5A5A; go("R3");
    en_a_n = 1; strb_host_n = 0; addr_i = 5; go("R3");
    host_read("R3", 6'd5);
    // Flow-through read then write, R8
    host_read("R8", 6'd1);
    ctl_write("R8", 6'd6, 32'h66666666);
    // Pipeline mode, R7 R10
    pipe_sel_i = 1;
    host_read("R7", 6'd1);
    host_read("R7", 6'd2);
    strb_ctl_n = 0; en_c_n = 1; go("R10");
    go("R10");
    go("R10");
    host_read("R7", 6'd3);
    step_n = 0; addr_i = 6; go("R7");
    go("R7");
    // Pipeline read followed by a write, R8
    host_read("R8", 6'd5);
    ctl_write("R8", 6'd7, 32'h77777777);
    go("R8");
    // Dummy reads with output enable high, R9
    strb_host_n = 0; out_en_n = 1; addr_i = 7; go("R9");
    step_n = 0; out_en_n = 1; go("R9");
    out_en_n = 1; go("R9");
    go("R9");
    pipe_sel_i = 0;
    host_read("R9", 6'd7);
    out_en_n = 1; go("R9");
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule